// File: doc/BRIEF.md
# Floating-Point Condition Predicate Unit

This block decides floating-point conditional instructions. It reads a 6-bit predicate code and the current condition bits: negative, zero and not-a-number. It reports whether the condition holds, flags predicate codes that are not defined, and produces a new exception byte. Predicates come in two groups. The unordered-aware group never raises an exception. The unordered-unaware group raises a branch-on-unordered exception when the not-a-number bit is set.

The same evaluation serves four instruction kinds. A conditional branch gets its target address, built from a short or a long displacement. A conditional trap gets its instruction advance and a trap request. A decrement-and-branch loop is handled by a clocked companion. That companion keeps a 32-bit counter. On each step strobe it either falls through or decrements the lower half of the counter and reports the relative branch advance. Displacement words arrive as inputs; the block does no memory fetch.

The predicate result, the branch target and the trap outputs are combinational. Only the loop counter and the loop result registers are clocked.

Top module: `fp_cond_unit`

## Requirements
- R1: A predicate value of 0x20 or above drives `pred_illegal_o` high and `cond_true_o` low, and `exc_o` passes `exc_i` through unchanged.
- R2: With predicate bits 4 and 3 clear, the low three bits select a base test over the condition bits (`cc_i[2]`=negative, `cc_i[1]`=zero, `cc_i[0]`=not-a-number). The tests are: 0 never true; 1 zero; 2 none of NaN, zero or negative; 3 zero, or neither NaN nor negative; 4 negative with neither NaN nor zero; 5 zero, or negative without NaN; 6 neither NaN nor zero; 7 no NaN.
- R3: When predicate bit 3 is set, the low nibble is complemented, the resulting base test is evaluated, and its result is inverted.
- R4: For a legal predicate, `exc_o` starts from all zeros regardless of `exc_i`. Bit 7 (the branch-on-unordered flag) is set only when predicate bit 4 is set and the NaN condition bit is set. Bit 4 does not change the truth result.
- R5: A loop step whose condition is true leaves the counter unchanged, clears `loop_taken_o` and gives `loop_adv_o` = 6.
- R6: A loop step whose condition is false and whose counter low half is nonzero decrements the low half, sets `loop_taken_o`, and gives `loop_adv_o` = 4 + the sign-extended 16-bit displacement in `disp_hi_i`.
- R7: A loop step whose condition is false and whose counter low half is zero wraps the low half to 0xFFFF, clears `loop_taken_o` and gives `loop_adv_o` = 6. The upper 16 bits of the counter are never changed by a step.
- R8: A loop step with an illegal predicate leaves the counter unchanged, sets `loop_fault_o`, and clears `loop_taken_o` and `loop_adv_o`.
- R9: `cnt_load_i` writes `cnt_wdata_i` into the counter on the next edge; a load takes priority over a step.
- R10: A true branch targets `pc_i` + 2 + displacement, where a long branch uses {`disp_hi_i`,`disp_lo_i`} and a short branch uses the sign-extended `disp_hi_i`. A branch that is not taken gives `pc_i` + 4 (short) or `pc_i` + 6 (long).
- R11: Trap operand mode 2, 3 or 4 gives a trap advance of 6, 8 or 4 and raises `trap_fire_o` when the condition is true. Any other mode sets `trap_mode_bad_o`, never fires, and reports an advance of 4.
- R12: After reset the counter, `loop_adv_o`, `loop_taken_o` and `loop_fault_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_i | input | 6 | Condition predicate code |
| cc_i | input | 3 | Condition bits {negative, zero, NaN} |
| exc_i | input | 8 | Current exception byte |
| cond_true_o | output | 1 | Predicate holds |
| pred_illegal_o | output | 1 | Predicate code undefined |
| exc_o | output | 8 | Updated exception byte |
| pc_i | input | 32 | Address of the current instruction |
| br_long_i | input | 1 | Branch uses a 32-bit displacement |
| disp_hi_i | input | 16 | Short displacement, or upper word of a long one |
| disp_lo_i | input | 16 | Lower word of a long displacement |
| br_target_o | output | 32 | Next address for a conditional branch |
| br_taken_o | output | 1 | Branch is taken |
| trap_mode_i | input | 3 | Trap operand mode |
| trap_adv_o | output | 4 | Trap instruction advance in bytes |
| trap_fire_o | output | 1 | Trap is requested |
| trap_mode_bad_o | output | 1 | Trap operand mode undefined |
| cnt_load_i | input | 1 | Load the loop counter |
| cnt_wdata_i | input | 32 | Value to load |
| loop_en_i | input | 1 | Perform one decrement-and-branch step |
| cnt_q_o | output | 32 | Loop counter |
| loop_adv_o | output | 32 | Relative advance from the last step |
| loop_taken_o | output | 1 | Last step branched |
| loop_fault_o | output | 1 | Last step had an illegal predicate |

## Verification
All 64 predicate codes are applied against six condition patterns: clear, zero, negative, NaN, negative with zero, and negative with NaN. Comparing these patterns separates every base test from its neighbours and from its negated form. The NaN patterns also separate the aware group from the unaware group, through the exception bit. The loop is stepped from a low half of 2 down through zero, so the borrow into 0xFFFF is checked and the upper half must stay intact. A negative displacement exposes any missing sign extension. Branches use a short displacement of 0x8000 and a long one of 0x00010000, and every trap mode is tried with both a true and a false condition.

// File: rtl/fp_cond_pkg.sv
// Shared constants for the floating-point condition predicate unit.
// Assumes the condition vector is ordered {negative, zero, NaN}.
package fp_cond_pkg;
    localparam int PRED_W   = 6;
    localparam int CC_W     = 3;
    localparam int CC_NAN   = 0;
    localparam int CC_ZERO  = 1;
    localparam int CC_NEG   = 2;
    localparam int EXC_W    = 8;
    localparam int EXC_BSUN = 7;

    typedef enum logic [2:0] {
        TRAP_WORD = 3'd2,
        TRAP_LONG = 3'd3,
        TRAP_NONE = 3'd4
    } trap_mode_e;
endpackage

// File: rtl/fp_pred_eval.sv
// Combinational predicate evaluator: decodes the 6-bit predicate, applies
// the negation and unordered-unaware rules, and forms the exception byte.
// Assumes exc_i is the byte in force before the instruction.
module fp_pred_eval
    import fp_cond_pkg::*;
(
    input  logic [PRED_W-1:0] pred_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic [EXC_W-1:0]  exc_i,
    output logic              cond_true_o,
    output logic              illegal_o,
    output logic [EXC_W-1:0]  exc_o
);
    logic       neg_sel;
    logic [2:0] base_sel;
    logic       base_res;
    logic       n, z, nan;

    // Decode the predicate fields and evaluate the selected base test
    always_comb begin
        n        = cc_i[CC_NEG];
        z        = cc_i[CC_ZERO];
        nan      = cc_i[CC_NAN];
        neg_sel  = pred_i[3];
        base_sel = pred_i[2:0] ^ {3{neg_sel}};
        case (base_sel)
            3'd0:    base_res = 1'b0;
            3'd1:    base_res = z;
            3'd2:    base_res = !(nan || z || n);
            3'd3:    base_res = z || !(nan || n);
            3'd4:    base_res = n && !nan && !z;
            3'd5:    base_res = z || (n && !nan);
            3'd6:    base_res = !(nan || z);
            default: base_res = !nan;
        endcase
    end

    // Combine result, illegal flag and exception byte
    always_comb begin
        illegal_o   = pred_i[5];
        cond_true_o = !illegal_o && (base_res ^ neg_sel);
        if (illegal_o) begin
            exc_o = exc_i;
        end else begin
            exc_o           = '0;
            exc_o[EXC_BSUN] = pred_i[4] && nan;
        end
    end
endmodule

// File: rtl/fp_flow_calc.sv
// Combinational next-address logic for conditional branch and conditional
// trap instructions. Assumes cond/illegal come from the predicate evaluator.
module fp_flow_calc #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 16
) (
    input  logic              cond_i,
    input  logic              illegal_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              long_i,
    input  logic [WORD_W-1:0] disp_hi_i,
    input  logic [WORD_W-1:0] disp_lo_i,
    output logic [ADDR_W-1:0] target_o,
    output logic              taken_o,
    input  logic [2:0]        trap_mode_i,
    output logic [3:0]        trap_adv_o,
    output logic              trap_fire_o,
    output logic              trap_bad_o
);
    import fp_cond_pkg::*;

    localparam int EXT_W = ADDR_W - WORD_W;

    logic [ADDR_W-1:0] disp_full;

    // Build the displacement and choose the next address
    always_comb begin
        if (long_i)
            disp_full = ADDR_W'({disp_hi_i, disp_lo_i});
        else
            disp_full = {{EXT_W{disp_hi_i[WORD_W-1]}}, disp_hi_i};
        taken_o = cond_i && !illegal_i;
        if (taken_o)
            target_o = pc_i + ADDR_W'(2) + disp_full;
        else
            target_o = pc_i + (long_i ? ADDR_W'(6) : ADDR_W'(4));
    end

    // Size the trap instruction from its operand mode
    always_comb begin
        trap_bad_o = 1'b0;
        case (trap_mode_i)
            TRAP_WORD: trap_adv_o = 4'd6;
            TRAP_LONG: trap_adv_o = 4'd8;
            TRAP_NONE: trap_adv_o = 4'd4;
            default: begin
                trap_adv_o = 4'd4;
                trap_bad_o = 1'b1;
            end
        endcase
        trap_fire_o = cond_i && !illegal_i && !trap_bad_o;
    end
endmodule

// File: rtl/fp_loop_ctl.sv
// Decrement-and-branch controller. On each step strobe it decrements the
// low half of the counter when the condition is false and reports the
// relative advance. Assumes the displacement is a signed half-width word.
module fp_loop_ctl #(
    parameter int CNT_W  = 32,
    parameter int ADV_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             step_i,
    input  logic             cond_i,
    input  logic             illegal_i,
    input  logic [CNT_W/2-1:0] disp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [ADV_W-1:0] adv_o,
    output logic             taken_o,
    output logic             fault_o
);
    localparam int HALF  = CNT_W / 2;
    localparam int EXT_W = ADV_W - HALF;

    logic [HALF-1:0]  low_q;
    logic [HALF-1:0]  high_q;
    logic [ADV_W-1:0] disp_ext;
    logic             low_zero;

    // Sign-extend the displacement and test the low half
    always_comb begin
        disp_ext = {{EXT_W{disp_i[HALF-1]}}, disp_i};
        low_zero = (low_q == '0);
    end

    // Counter: load has priority; a step touches only the low half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
        end else if (load_i) begin
            low_q  <= wdata_i[HALF-1:0];
            high_q <= wdata_i[CNT_W-1:HALF];
        end else if (step_i && !illegal_i && !cond_i) begin
            low_q  <= low_q - HALF'(1);
        end
    end

    // Step result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_o   <= '0;
            taken_o <= 1'b0;
            fault_o <= 1'b0;
        end else if (step_i && !load_i) begin
            fault_o <= illegal_i;
            if (illegal_i) begin
                adv_o   <= '0;
                taken_o <= 1'b0;
            end else if (!cond_i && !low_zero) begin
                adv_o   <= ADV_W'(4) + disp_ext;
                taken_o <= 1'b1;
            end else begin
                adv_o   <= ADV_W'(6);
                taken_o <= 1'b0;
            end
        end
    end

    assign cnt_o = {high_q, low_q};

    // R7
    upper_half_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (cnt_o[CNT_W-1:HALF] == $past(cnt_o[CNT_W-1:HALF])));
    // R5
    true_cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && cond_i && !illegal_i) |=> (cnt_o == $past(cnt_o) && !taken_o));
    // R8
    illegal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && illegal_i) |=> (fault_o && !taken_o && cnt_o == $past(cnt_o)));
endmodule

// File: rtl/fp_cond_unit.sv
// Top of the floating-point condition predicate unit: the predicate
// evaluator feeds the branch/trap next-address logic and the loop controller.
// Assumes one instruction is presented at a time on the shared inputs.
module fp_cond_unit
    import fp_cond_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        pred_i,
    input  logic [2:0]        cc_i,
    input  logic [7:0]        exc_i,
    output logic              cond_true_o,
    output logic              pred_illegal_o,
    output logic [7:0]        exc_o,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              br_long_i,
    input  logic [15:0]       disp_hi_i,
    input  logic [15:0]       disp_lo_i,
    output logic [ADDR_W-1:0] br_target_o,
    output logic              br_taken_o,
    input  logic [2:0]        trap_mode_i,
    output logic [3:0]        trap_adv_o,
    output logic              trap_fire_o,
    output logic              trap_mode_bad_o,
    input  logic              cnt_load_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic              loop_en_i,
    output logic [CNT_W-1:0]  cnt_q_o,
    output logic [ADDR_W-1:0] loop_adv_o,
    output logic              loop_taken_o,
    output logic              loop_fault_o
);
    fp_pred_eval u_pred (
        .pred_i     (pred_i),
        .cc_i       (cc_i),
        .exc_i      (exc_i),
        .cond_true_o(cond_true_o),
        .illegal_o  (pred_illegal_o),
        .exc_o      (exc_o)
    );

    fp_flow_calc #(.ADDR_W(ADDR_W), .WORD_W(16)) u_flow (
        .cond_i     (cond_true_o),
        .illegal_i  (pred_illegal_o),
        .pc_i       (pc_i),
        .long_i     (br_long_i),
        .disp_hi_i  (disp_hi_i),
        .disp_lo_i  (disp_lo_i),
        .target_o   (br_target_o),
        .taken_o    (br_taken_o),
        .trap_mode_i(trap_mode_i),
        .trap_adv_o (trap_adv_o),
        .trap_fire_o(trap_fire_o),
        .trap_bad_o (trap_mode_bad_o)
    );

    fp_loop_ctl #(.CNT_W(CNT_W), .ADV_W(ADDR_W)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (cnt_load_i),
        .wdata_i  (cnt_wdata_i),
        .step_i   (loop_en_i),
        .cond_i   (cond_true_o),
        .illegal_i(pred_illegal_o),
        .disp_i   (disp_hi_i),
        .cnt_o    (cnt_q_o),
        .adv_o    (loop_adv_o),
        .taken_o  (loop_taken_o),
        .fault_o  (loop_fault_o)
    );

    // R1
    illegal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_illegal_o |-> (!cond_true_o && !br_taken_o && !trap_fire_o && exc_o == exc_i));
    // R4
    aware_no_bsun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_i[4] && !pred_illegal_o) |-> (exc_o == 8'h00));
    // R11
    trap_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire_o |-> (trap_adv_o == 4'd4 || trap_adv_o == 4'd6 || trap_adv_o == 4'd8));
    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load_i |=> (cnt_q_o == $past(cnt_wdata_i)));
endmodule

// File: tb/fp_cond_unit_test.sv
module fp_cond_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pred_i = '0;
    logic [2:0]  cc_i = '0;
    logic [7:0]  exc_i = '0;
    logic        cond_true_o, pred_illegal_o;
    logic [7:0]  exc_o;
    logic [31:0] pc_i = '0;
    logic        br_long_i = 1'b0;
    logic [15:0] disp_hi_i = '0, disp_lo_i = '0;
    logic [31:0] br_target_o;
    logic        br_taken_o;
    logic [2:0]  trap_mode_i = '0;
    logic [3:0]  trap_adv_o;
    logic        trap_fire_o, trap_mode_bad_o;
    logic        cnt_load_i = 1'b0;
    logic [31:0] cnt_wdata_i = '0;
    logic        loop_en_i = 1'b0;
    logic [31:0] cnt_q_o, loop_adv_o;
    logic        loop_taken_o, loop_fault_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp_cond_unit uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference truth from the requirement table; cc = {neg, zero, nan}
    function automatic bit ref_truth(input int p, input logic [2:0] cc);
        bit n, z, q, r, inv;
        int b;
        n = cc[2]; z = cc[1]; q = cc[0];
        if (p >= 32) return 1'b0;
        b = p & 15;
        inv = (b >= 8);
        if (inv) b = b ^ 15;
        case (b)
            0: r = 0;
            1: r = z;
            2: r = !q && !z && !n;
            3: r = z || (!q && !n);
            4: r = n && !q && !z;
            5: r = z || (n && !q);
            6: r = !q && !z;
            default: r = !q;
        endcase
        return r ^ inv;
    endfunction

    task automatic t_reset();
        chk("R12 cnt", cnt_q_o, 32'h0);
        chk("R12 adv", loop_adv_o, 32'h0);
        chk("R12 taken", {31'b0, loop_taken_o}, 32'h0);
        chk("R12 fault", {31'b0, loop_fault_o}, 32'h0);
    endtask

    task automatic t_predicates();
        logic [2:0] pats [6] = '{3'b000, 3'b010, 3'b100, 3'b001, 3'b110, 3'b101};
        for (int p = 0; p < 64; p++) begin
            for (int k = 0; k < 6; k++) begin
                pred_i = p[5:0]; cc_i = pats[k]; exc_i = 8'h5A;
                #1;
                if (p >= 32) begin
                    chk("R1 illegal", {31'b0, pred_illegal_o}, 32'h1);
                    chk("R1 cond", {31'b0, cond_true_o}, 32'h0);
                    chk("R1 exc", {24'b0, exc_o}, 32'h5A);
                end else begin
                    chk(p[3] ? "R3 negated" : "R2 base", {31'b0, cond_true_o},
                        {31'b0, ref_truth(p, pats[k])});
                    chk("R4 exc", {24'b0, exc_o},
                        {24'b0, (p[4] && pats[k][0]) ? 8'h80 : 8'h00});
                end
            end
        end
    endtask

    task automatic step(input logic [5:0] p, input logic [2:0] cc, input logic [15:0] d);
        @(negedge clk);
        pred_i = p; cc_i = cc; disp_hi_i = d; loop_en_i = 1'b1;
        @(negedge clk);
        loop_en_i = 1'b0;
    endtask

    task automatic t_loop();
        @(negedge clk);
        cnt_load_i = 1'b1; cnt_wdata_i = 32'h1234_0002; loop_en_i = 1'b1;
        pred_i = 6'h00;
        @(negedge clk);
        cnt_load_i = 1'b0; loop_en_i = 1'b0;
        chk("R9 load over step", cnt_q_o, 32'h1234_0002);
        step(6'h00, 3'b000, 16'hFFF0);
        chk("R6 cnt", cnt_q_o, 32'h1234_0001);
        chk("R6 adv", loop_adv_o, 32'hFFFF_FFF4);
        chk("R6 taken", {31'b0, loop_taken_o}, 32'h1);
        step(6'h00, 3'b000, 16'h0010);
        chk("R6 cnt2", cnt_q_o, 32'h1234_0000);
        chk("R6 adv2", loop_adv_o, 32'h0000_0014);
        step(6'h00, 3'b000, 16'h0010);
        chk("R7 wrap", cnt_q_o, 32'h1234_FFFF);
        chk("R7 adv", loop_adv_o, 32'h6);
        chk("R7 taken", {31'b0, loop_taken_o}, 32'h0);
        step(6'h0F, 3'b000, 16'h0010);
        chk("R5 cnt", cnt_q_o, 32'h1234_FFFF);
        chk("R5 adv", loop_adv_o, 32'h6);
        chk("R5 taken", {31'b0, loop_taken_o}, 32'h0);
        step(6'h21, 3'b000, 16'h0010);
        chk("R8 cnt", cnt_q_o, 32'h1234_FFFF);
        chk("R8 fault", {31'b0, loop_fault_o}, 32'h1);
        chk("R8 adv", loop_adv_o, 32'h0);
    endtask

    task automatic t_branch();
        pc_i = 32'h0000_1000; cc_i = 3'b000;
        pred_i = 6'h0F; br_long_i = 1'b0; disp_hi_i = 16'h8000; #1;
        chk("R10 short taken", br_target_o, 32'hFFFF_9002);
        chk("R10 taken flag", {31'b0, br_taken_o}, 32'h1);
        br_long_i = 1'b1; disp_hi_i = 16'h0001; disp_lo_i = 16'h0000; #1;
        chk("R10 long taken", br_target_o, 32'h0001_1002);
        pred_i = 6'h00; #1;
        chk("R10 long not taken", br_target_o, 32'h0000_1006);
        br_long_i = 1'b0; #1;
        chk("R10 short not taken", br_target_o, 32'h0000_1004);
    endtask

    task automatic t_trap();
        for (int m = 0; m < 8; m++) begin
            trap_mode_i = m[2:0];
            pred_i = 6'h0F; #1;
            if (m >= 2 && m <= 4) begin
                chk("R11 adv", {28'b0, trap_adv_o}, (m == 2) ? 32'd6 : (m == 3) ? 32'd8 : 32'd4);
                chk("R11 fire", {31'b0, trap_fire_o}, 32'h1);
                chk("R11 ok", {31'b0, trap_mode_bad_o}, 32'h0);
            end else begin
                chk("R11 bad", {31'b0, trap_mode_bad_o}, 32'h1);
                chk("R11 nofire", {31'b0, trap_fire_o}, 32'h0);
                chk("R11 bad adv", {28'b0, trap_adv_o}, 32'd4);
            end
            pred_i = 6'h00; #1;
            chk("R11 false nofire", {31'b0, trap_fire_o}, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_predicates();
        t_loop();
        t_branch();
        t_trap();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule